// File: doc/BRIEF.md
# Device-Erasure Cache-Line ECC Codec

This block protects one half of a cache line, 256 data bits, for storage across eighteen memory devices. Each device is four bits wide and is read over four beats, so it holds a 16-bit slice of the stored word. On the write side a 16-bit CRC is computed over the data. A 16-bit even-parity slice then covers the data and the CRC, giving a 288-bit word: sixteen data devices, one CRC device and one parity device.

On the read side the codec recomputes the CRC and compares it with the stored CRC slice. Until a device is marked as failed, the codec only checks for errors. Once an external agent marks a device through the tag inputs, every read rebuilds that device's slice from the parity slice and the other slices. The CRC then checks the rebuilt word. If the check still fails, the codec looks for the one single-bit fault in another device that explains the CRC syndrome. When exactly one such fault fits, it corrects the fault. Otherwise it reports the read as uncorrectable.

The write path and the read path are independent. Each has one cycle of latency.

Top module: `erasure_line_codec`

## Requirements
- R1: Device d (0 to 17) occupies bits [16d+15:16d] of the stored word. Devices 0 to 15 carry data bits [16d+15:16d], device 16 carries the CRC and device 17 carries the parity. `wrWord` and `wrOutValid` are updated on the clock edge that samples `wrValid`, one cycle after the request.
- R2: The CRC uses the polynomial 0x1021 (x^16+x^12+x^5+1) with an all-zero seed. Data bit 255 is shifted in first and bit 0 last, with no final inversion.
- R3: The parity slice is the bitwise XOR of the sixteen data slices and the CRC slice, so the XOR of all eighteen slices of an encoded word is zero.
- R4: On an untagged read whose CRC matches, `rdData` returns the stored data bits with no flag. On an untagged read whose CRC does not match, the data is returned unmodified, `rdUncorr` is set and no correction is made.
- R5: When `tagEn` is high and `tagDev` is 0 to 16, that device's slice is replaced by the XOR of the other seventeen slices before the check. Any content in the tagged device then has no effect on `rdData`, and no flag is raised.
- R6: On a tagged read that fails the CRC, a single-bit error at slice bit j of another device is corrected when it is the only single-bit candidate that makes the CRC match. The correction flips bit j of that device, and also bit j of the tagged slice when the tagged slice was rebuilt. `rdCorr` is then set.
- R7: A tagged read that fails the CRC with zero candidates, or with more than one, returns the uncorrected data and sets `rdUncorr`. `rdCorr` and `rdUncorr` are never high together.
- R8: `rdOutValid`, `rdData`, `rdCorr`, `rdUncorr` and `errPulse` are updated one cycle after `rdValid`. `errPulse` is high for exactly that one cycle when the read failed its first CRC check, whether or not it was corrected.
- R9: `uncorrSticky` sets on every uncorrectable read and stays set until `clrErr`. A clear in the same cycle as an uncorrectable read wins.
- R10: A `tagDev` value above 17, or `tagEn` low, makes the read untagged. When `tagDev` is 17 (the parity device), nothing is rebuilt, but single-bit correction per R6 is still attempted.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Encode request |
| wrData | input | 256 | Half cache line to encode |
| wrOutValid | output | 1 | Encoded word valid |
| wrWord | output | 288 | Encoded word, eighteen 16-bit device slices |
| rdValid | input | 1 | Decode request |
| rdWord | input | 288 | Stored word read back |
| tagEn | input | 1 | A failed device is marked |
| tagDev | input | 5 | Index of the failed device |
| clrErr | input | 1 | Clears the sticky uncorrectable flag |
| rdOutValid | output | 1 | Decoded data valid |
| rdData | output | 256 | Decoded data |
| rdCorr | output | 1 | The read was corrected |
| rdUncorr | output | 1 | The read was uncorrectable |
| errPulse | output | 1 | One-cycle pulse for any read that failed its check |
| uncorrSticky | output | 1 | Sticky uncorrectable indication |

## Verification
The assertions take for granted that `tagEn` and `tagDev` are stable with `rdValid`. They also take for granted that `clrErr` is a plain level sampled at the clock edge. Correction properties therefore relate `rdCorr` to the tag values one cycle earlier.

The stimulus drives each request for exactly one cycle, on the falling edge. It holds the tag inputs with the read word and keeps `tagDev` inside the five-bit field, including the out-of-range values 18 to 31 on purpose. The random fault patterns are built from encoded words, with a garbage slice in the tagged device and at most one or two extra flipped bits. The expected results come from a bench model that searches every candidate flip by full CRC recomputation.

// File: rtl/elc_pkg.sv
package elc_pkg;
  localparam int DEV_BITS  = 4;
  localparam int BEATS     = 4;
  localparam int SLICE_W   = DEV_BITS * BEATS;
  localparam int DATA_DEVS = 16;
  localparam int CRC_DEV   = DATA_DEVS;
  localparam int PAR_DEV   = DATA_DEVS + 1;
  localparam int NUM_DEVS  = DATA_DEVS + 2;
  localparam int DATA_W    = DATA_DEVS * SLICE_W;
  localparam int CHK_W     = (DATA_DEVS + 1) * SLICE_W;
  localparam int WORD_W    = NUM_DEVS * SLICE_W;
  localparam int CRC_W     = SLICE_W;
  localparam int IDX_W     = $clog2(NUM_DEVS);
  localparam int CAND_N    = (DATA_DEVS + 1) * SLICE_W;

  typedef struct packed {
    logic wrLoad;
    logic rdLoad;
    logic applyFix;
  } strobe_t;

  // MSB-first CRC over the data payload, zero seed
  function automatic logic [CRC_W-1:0] crcOf(input logic [DATA_W-1:0] d,
                                             input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

  // Syndrome produced by one flipped bit of a data or CRC slice
  function automatic logic [CRC_W-1:0] contrib(input int dev, input int pos,
                                               input logic [CRC_W-1:0] poly);
    logic [DATA_W-1:0] v;
    v = '0;
    if (dev < DATA_DEVS) begin
      v[dev*SLICE_W+pos] = 1'b1;
      return crcOf(v, poly);
    end
    if (dev == CRC_DEV) return CRC_W'(1) << pos;
    return '0;
  endfunction
endpackage

// File: rtl/elc_datapath.sv
module elc_datapath
  import elc_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [WORD_W-1:0] rdWord,
  input  logic              tagEn,
  input  logic [IDX_W-1:0]  tagDev,
  output logic [WORD_W-1:0] wrWord,
  output logic [DATA_W-1:0] rdData,
  output logic              synZero,
  output logic              fixUnique,
  output logic              tagActive
);
  // ---------------- encode ----------------
  logic [CRC_W-1:0]   encCrc;
  logic [SLICE_W-1:0] encPar;

  always_comb begin
    encCrc = crcOf(wrData, CRC_POLY);
    encPar = encCrc;
    for (int d = 0; d < DATA_DEVS; d++) encPar = encPar ^ wrData[d*SLICE_W +: SLICE_W];
  end

  // ---------------- decode: erasure rebuild ----------------
  logic               tagRebuild;
  logic [SLICE_W-1:0] parSyn;
  logic [CHK_W-1:0]   rebuilt;
  logic [CRC_W-1:0]   syn;

  assign tagRebuild = tagEn && (tagDev <= IDX_W'(CRC_DEV));
  assign tagActive  = tagEn && (tagDev <= IDX_W'(PAR_DEV));

  always_comb begin
    parSyn = '0;
    for (int d = 0; d < NUM_DEVS; d++) parSyn = parSyn ^ rdWord[d*SLICE_W +: SLICE_W];
  end

  always_comb begin
    rebuilt = rdWord[CHK_W-1:0];
    for (int d = 0; d <= CRC_DEV; d++) begin
      if (tagRebuild && tagDev == IDX_W'(d))
        rebuilt[d*SLICE_W +: SLICE_W] = rdWord[d*SLICE_W +: SLICE_W] ^ parSyn;
    end
  end

  assign syn     = crcOf(rebuilt[DATA_W-1:0], CRC_POLY) ^ rebuilt[CHK_W-1:DATA_W];
  assign synZero = (syn == '0);

  // ---------------- decode: single-bit candidate search ----------------
  logic [CRC_W-1:0]  kTab [CRC_DEV+1][SLICE_W];
  logic [CRC_W-1:0]  tagC [SLICE_W];
  logic [CAND_N-1:0] cand;
  logic [SLICE_W-1:0] colHit;

  for (genvar gd = 0; gd <= CRC_DEV; gd++) begin : g_dev
    for (genvar gj = 0; gj < SLICE_W; gj++) begin : g_bit
      localparam logic [CRC_W-1:0] K = contrib(gd, gj, CRC_POLY);
      assign kTab[gd][gj] = K;
    end
  end

  always_comb begin
    for (int j = 0; j < SLICE_W; j++) begin
      tagC[j] = '0;
      for (int d = 0; d <= CRC_DEV; d++)
        if (tagRebuild && tagDev == IDX_W'(d)) tagC[j] = kTab[d][j];
    end
  end

  for (genvar gd = 0; gd <= CRC_DEV; gd++) begin : g_cand_dev
    for (genvar gj = 0; gj < SLICE_W; gj++) begin : g_cand_bit
      assign cand[gd*SLICE_W+gj] = tagActive && !synZero &&
                                   (tagDev != IDX_W'(gd)) &&
                                   (syn == (kTab[gd][gj] ^ tagC[gj]));
    end
  end

  always_comb begin
    colHit = '0;
    for (int d = 0; d <= CRC_DEV; d++)
      for (int j = 0; j < SLICE_W; j++)
        colHit[j] = colHit[j] | cand[d*SLICE_W+j];
  end

  assign fixUnique = ($countones(cand) == 1);

  logic [DATA_W-1:0] fixedData;
  always_comb begin
    fixedData = rebuilt[DATA_W-1:0];
    for (int d = 0; d < DATA_DEVS; d++)
      for (int j = 0; j < SLICE_W; j++)
        if (cand[d*SLICE_W+j] || (tagRebuild && tagDev == IDX_W'(d) && colHit[j]))
          fixedData[d*SLICE_W+j] = ~fixedData[d*SLICE_W+j];
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrWord <= '0;
      rdData <= '0;
    end else begin
      if (strb.wrLoad) wrWord <= {encPar, encCrc, wrData};
      if (strb.rdLoad) rdData <= strb.applyFix ? fixedData : rebuilt[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/elc_control.sv
module elc_control
  import elc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wrValid,
  input  logic    rdValid,
  input  logic    clrErr,
  input  logic    synZero,
  input  logic    fixUnique,
  input  logic    tagActive,
  output strobe_t strb,
  output logic    wrOutValid,
  output logic    rdOutValid,
  output logic    rdCorr,
  output logic    rdUncorr,
  output logic    errPulse,
  output logic    uncorrSticky
);
  logic goodFix, badRead;

  assign goodFix = !synZero && tagActive && fixUnique;
  assign badRead = !synZero && !goodFix;

  always_comb begin
    strb.wrLoad   = wrValid;
    strb.rdLoad   = rdValid;
    strb.applyFix = rdValid && goodFix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrOutValid   <= 1'b0;
      rdOutValid   <= 1'b0;
      rdCorr       <= 1'b0;
      rdUncorr     <= 1'b0;
      errPulse     <= 1'b0;
      uncorrSticky <= 1'b0;
    end else begin
      wrOutValid <= wrValid;
      rdOutValid <= rdValid;
      rdCorr     <= rdValid && goodFix;
      rdUncorr   <= rdValid && badRead;
      errPulse   <= rdValid && !synZero;
      if (clrErr)                    uncorrSticky <= 1'b0;
      else if (rdValid && badRead)   uncorrSticky <= 1'b1;
    end
  end
endmodule

// File: rtl/erasure_line_codec.sv
module erasure_line_codec
  import elc_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrOutValid,
  output logic [WORD_W-1:0] wrWord,
  input  logic              rdValid,
  input  logic [WORD_W-1:0] rdWord,
  input  logic              tagEn,
  input  logic [IDX_W-1:0]  tagDev,
  input  logic              clrErr,
  output logic              rdOutValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdCorr,
  output logic              rdUncorr,
  output logic              errPulse,
  output logic              uncorrSticky
);
  strobe_t strb;
  logic synZero, fixUnique, tagActive;

  elc_datapath #(.CRC_POLY(CRC_POLY)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData), .rdWord(rdWord),
    .tagEn(tagEn), .tagDev(tagDev), .wrWord(wrWord), .rdData(rdData),
    .synZero(synZero), .fixUnique(fixUnique), .tagActive(tagActive)
  );

  elc_control u_ctl (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .rdValid(rdValid), .clrErr(clrErr),
    .synZero(synZero), .fixUnique(fixUnique), .tagActive(tagActive), .strb(strb),
    .wrOutValid(wrOutValid), .rdOutValid(rdOutValid), .rdCorr(rdCorr),
    .rdUncorr(rdUncorr), .errPulse(errPulse), .uncorrSticky(uncorrSticky)
  );
endmodule

// File: rtl/erasure_line_codec_chk.sv
module erasure_line_codec_chk
  import elc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wrValid,
  input logic              wrOutValid,
  input logic [WORD_W-1:0] wrWord,
  input logic              rdValid,
  input logic              tagEn,
  input logic [IDX_W-1:0]  tagDev,
  input logic              clrErr,
  input logic              rdOutValid,
  input logic              rdCorr,
  input logic              rdUncorr,
  input logic              errPulse,
  input logic              uncorrSticky
);
  logic [SLICE_W-1:0] allXor;
  always_comb begin
    allXor = '0;
    for (int d = 0; d < NUM_DEVS; d++) allXor = allXor ^ wrWord[d*SLICE_W +: SLICE_W];
  end

  a_r1_wr_latency: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid |=> wrOutValid);
  a_r1_wr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wrValid |=> !wrOutValid);
  a_r3_parity_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrOutValid |-> (allXor == '0));
  a_r8_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |=> rdOutValid);
  a_r8_err_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    errPulse |-> rdOutValid);
  a_r8_flag_implies_err: assert property (@(posedge clk) disable iff (!rst_n)
    (rdCorr || rdUncorr) |-> errPulse);
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rdCorr, rdUncorr}));
  a_r10_fix_needs_tag: assert property (@(posedge clk) disable iff (!rst_n)
    rdCorr |-> $past(tagEn && tagDev <= IDX_W'(PAR_DEV)));
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clrErr |=> !uncorrSticky);
  a_r9_set_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rdUncorr && !$past(clrErr)) |-> uncorrSticky);
endmodule

bind erasure_line_codec erasure_line_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrOutValid(wrOutValid), .wrWord(wrWord),
  .rdValid(rdValid), .tagEn(tagEn), .tagDev(tagDev), .clrErr(clrErr),
  .rdOutValid(rdOutValid), .rdCorr(rdCorr), .rdUncorr(rdUncorr),
  .errPulse(errPulse), .uncorrSticky(uncorrSticky)
);

// File: tb/erasure_line_codec_tb.sv
module erasure_line_codec_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrValid = 1'b0;
  logic [255:0] wrData = '0;
  logic wrOutValid;
  logic [287:0] wrWord;
  logic rdValid = 1'b0;
  logic [287:0] rdWord = '0;
  logic tagEn = 1'b0;
  logic [4:0] tagDev = '0;
  logic clrErr = 1'b0;
  logic rdOutValid;
  logic [255:0] rdData;
  logic rdCorr, rdUncorr, errPulse, uncorrSticky;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  int nCorrSeen = 0;
  int nUncorrSeen = 0;

  always #2.5 clk = ~clk;

  erasure_line_codec u_dut (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrData(wrData),
    .wrOutValid(wrOutValid), .wrWord(wrWord), .rdValid(rdValid), .rdWord(rdWord),
    .tagEn(tagEn), .tagDev(tagDev), .clrErr(clrErr), .rdOutValid(rdOutValid),
    .rdData(rdData), .rdCorr(rdCorr), .rdUncorr(rdUncorr), .errPulse(errPulse),
    .uncorrSticky(uncorrSticky)
  );

  task automatic chk(input bit ok, input string req, input logic [287:0] act,
                     input logic [287:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------- reference model (R2, R1, R3) ----------
  function automatic logic [15:0] crcM(input logic [255:0] d);
    logic [15:0] r = 16'h0;
    for (int i = 255; i >= 0; i--) begin
      logic top = r[15];
      r = r << 1;
      if (top != d[i]) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [287:0] encodeM(input logic [255:0] d);
    logic [15:0] c = crcM(d);
    logic [15:0] p = c;
    for (int k = 0; k < 16; k++) p = p ^ d[k*16 +: 16];
    return {p, c, d};
  endfunction

  task automatic decodeM(input logic [287:0] w, input bit te, input int td,
                         output logic [255:0] dOut, output bit corr, output bit unc);
    logic [287:0] rb = w;
    bit active = te && td <= 17;
    bit reb = te && td <= 16;
    int count = 0;
    logic [255:0] keep = '0;
    if (reb) begin
      logic [15:0] x = '0;
      for (int k = 0; k < 18; k++) if (k != td) x = x ^ w[k*16 +: 16];
      rb[td*16 +: 16] = x;
    end
    corr = 0; unc = 0; dOut = rb[255:0];
    if (crcM(rb[255:0]) == rb[271:256]) return;
    if (!active) begin unc = 1; return; end
    for (int k = 0; k < 17; k++) begin
      if (k == td) continue;
      for (int j = 0; j < 16; j++) begin
        logic [287:0] t = rb;
        t[k*16+j] = ~t[k*16+j];
        if (reb) t[td*16+j] = ~t[td*16+j];
        if (crcM(t[255:0]) == t[271:256]) begin count++; keep = t[255:0]; end
      end
    end
    if (count == 1) begin corr = 1; dOut = keep; end
    else unc = 1;
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // ---------- drivers ----------
  task automatic doWrite(input logic [255:0] d, input string req);
    logic [287:0] exp = encodeM(d);
    @(negedge clk); wrValid = 1; wrData = d;
    @(negedge clk); wrValid = 0;
    chk(wrOutValid == 1'b1, {req, " wrOutValid"}, 288'(wrOutValid), 288'd1);
    chk(wrWord == exp, req, wrWord, exp);
  endtask

  task automatic doRead(input logic [287:0] w, input bit te, input logic [4:0] td,
                        input string req);
    logic [255:0] eD; bit eC, eU;
    decodeM(w, te, int'(td), eD, eC, eU);
    if (eC) nCorrSeen++;
    if (eU) nUncorrSeen++;
    @(negedge clk); rdValid = 1; rdWord = w; tagEn = te; tagDev = td;
    @(negedge clk); rdValid = 0; tagEn = 0;
    chk(rdOutValid == 1'b1, {req, " R8 rdOutValid"}, 288'(rdOutValid), 288'd1);
    chk(rdData == eD, {req, " data"}, 288'(rdData), 288'(eD));
    chk(rdCorr == eC, {req, " R6 rdCorr"}, 288'(rdCorr), 288'(eC));
    chk(rdUncorr == eU, {req, " R7 rdUncorr"}, 288'(rdUncorr), 288'(eU));
    chk(errPulse == (eC | eU), {req, " R8 errPulse"}, 288'(errPulse), 288'(eC | eU));
    if (eU) chk(uncorrSticky == 1'b1, "R9 sticky set", 288'(uncorrSticky), 288'd1);
    @(negedge clk);
    chk(errPulse == 1'b0 && rdOutValid == 1'b0, "R8 single-cycle pulse",
        288'({errPulse, rdOutValid}), 288'd0);
  endtask

  task automatic doClear();
    @(negedge clk); clrErr = 1;
    @(negedge clk); clrErr = 0;
    chk(uncorrSticky == 1'b0, "R9 clear", 288'(uncorrSticky), 288'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [255:0] d;
    logic [287:0] w;
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({wrOutValid, rdOutValid, rdCorr, rdUncorr, errPulse, uncorrSticky} == 6'd0,
        "R11 reset flags", 288'({wrOutValid, rdOutValid, rdCorr, rdUncorr, errPulse, uncorrSticky}), 288'd0);
    chk(wrWord == '0 && rdData == '0, "R11 reset data", wrWord, 288'd0);
    rst_n = 1;

    // R1/R2/R3 directed and random encodes
    doWrite('0, "R1 R2 zero word");
    doWrite(256'd1, "R2 single low bit");
    doWrite({1'b1, 255'd0}, "R2 single high bit");
    doWrite({256{1'b1}}, "R3 all ones");
    for (int i = 0; i < 12; i++) doWrite(rnd256(), "R1 R2 R3 random encode");

    // R4 clean and failing untagged reads
    d = rnd256();
    doRead(encodeM(d), 0, 5'd0, "R4 clean untagged");
    w = encodeM(d); w[37] = ~w[37];
    doRead(w, 0, 5'd0, "R4 untagged single-bit fault");
    doClear();

    // R5 rebuild of a tagged device with garbage content
    for (int i = 0; i < 17; i++) begin
      d = rnd256(); w = encodeM(d);
      w[i*16 +: 16] = w[i*16 +: 16] ^ (16'($urandom) | 16'h1);
      doRead(w, 1, 5'(i), "R5 rebuild tagged device");
    end

    // R10 out-of-range tag and tagEn low behave as untagged
    d = rnd256(); w = encodeM(d); w[3*16 +: 16] = ~w[3*16 +: 16];
    doRead(w, 1, 5'd20, "R10 tag index out of range");
    doRead(w, 0, 5'd3, "R10 tag disabled");
    doRead(w, 1, 5'd3, "R5 same word tagged");
    doClear();

    // R6 tagged device plus one extra bit fault, including parity-device tag
    for (int i = 0; i < 30; i++) begin
      int t = $urandom % 18;
      int e = $urandom % 17;
      int j = $urandom % 16;
      if (e == t) e = (e + 1) % 17;
      d = rnd256(); w = encodeM(d);
      w[t*16 +: 16] = w[t*16 +: 16] ^ 16'($urandom);
      w[e*16 + j] = ~w[e*16 + j];
      doRead(w, 1, 5'(t), "R6 R10 extra single-bit fault");
    end

    // R7 two extra faults in distinct devices
    for (int i = 0; i < 8; i++) begin
      int t = $urandom % 17;
      int a = (t + 1) % 17;
      int b = (t + 2 + ($urandom % 14)) % 17;
      d = rnd256(); w = encodeM(d);
      w[a*16 + 2] = ~w[a*16 + 2];
      w[b*16 + 9] = ~w[b*16 + 9];
      doRead(w, 1, 5'(t), "R7 double fault");
    end

    // R9 clear wins over a simultaneous uncorrectable read
    d = rnd256(); w = encodeM(d); w[100] = ~w[100];
    @(negedge clk); rdValid = 1; rdWord = w; tagEn = 0; clrErr = 1;
    @(negedge clk); rdValid = 0; clrErr = 0;
    chk(rdUncorr == 1'b1, "R9 R4 flag with clear", 288'(rdUncorr), 288'd1);
    chk(uncorrSticky == 1'b0, "R9 clear wins", 288'(uncorrSticky), 288'd0);

    chk(nCorrSeen > 0, "R6 some corrections exercised", 288'(nCorrSeen), 288'd1);
    chk(nUncorrSeen > 0, "R7 some failures exercised", 288'(nUncorrSeen), 288'd1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule